// File: doc/BRIEF.md
# Multi-Channel Interval Timer

A bank of six independent 32-bit up-counters behind a small register bus. Each channel picks one of two count-enable strobes, a fast system tick or a slow real-time tick, optionally halved, and counts while enabled. A channel can stop after reaching its compare value, restart from zero at that value, or run freely and ignore the compare value. When a channel reaches its compare value it latches a pending flag. A shared mask register gates these flags onto a single interrupt line, and software clears them by writing ones to an acknowledge register.

The register space is split into 16-byte slots. Slot 0 holds the shared interrupt registers. Slot n, for n from 1 to 6, holds the four registers of channel n. A register access takes one cycle. A read returns its data on `rdata_o` in the cycle after the request.

Top module: `gp_timer_bank`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: The address map is as follows. Offset 0x00 is the interrupt mask, where bit n-1 belongs to channel n. Offset 0x08 returns the pending flags on read. Offset 0x04 and every slot above 6 read as 0. For channel n, the control register is at 0x10*n: bit 0 is run, bit 1 is clear, and bits 5:4 are the mode (0 stop-at-match, 1 restart, 2 same as 0, 3 free). The source register is at 0x10*n+4: bit 4 selects the slow tick, and bit 0 selects divide by two. The counter is at 0x10*n+8 and can be written. The compare value is at 0x10*n+0xC. The clear bit always reads 0. Read data appears on `rdata_o` one cycle after the request.
- R3: A control write with the clear bit set makes the counter read 0 on the next access. Counting then resumes from 0.
- R4: An enabled channel advances by one on each strobe of its selected source and ignores the other source. With divide by two it advances on every second strobe, counted from the last clear.
- R5: In stop-at-match mode, reaching the compare value sets the pending flag and drops the run bit. The counter then holds that value.
- R6: In restart mode, reaching the compare value sets the pending flag. The next count strobe returns the counter to 0, so the period is compare+1 strobes.
- R7: In free mode the counter wraps from 0xFFFFFFFF to 0 and never sets a pending flag.
- R8: Clearing the run bit freezes the counter and leaves the mode, compare and source settings unchanged.
- R9: `irq_o` is high exactly when some pending flag and its mask bit are both 1. A flag is latched even while its mask bit is 0.
- R10: Writing to 0x08 clears only the flags whose bits are written as 1. A flag that is set in the same cycle as its acknowledge stays set.
- R11: Channels are independent: activity in one channel changes no other channel's registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fast_tick_i | input | 1 | Fast count strobe |
| slow_tick_i | input | 1 | Slow real-time count strobe |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two events can land on the same clock edge: a channel reaching its compare value, which sets its flag, and a software acknowledge write to that same flag. The bench provokes this by driving the acknowledge write and the count strobe that completes the match on the same edge. It then reads the pending register and expects the flag still set. Another flag that was acknowledged in the same write must read clear.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  typedef enum logic [1:0] {
    M_ONCE = 2'd0,
    M_REP  = 2'd1,
    M_RSVD = 2'd2,
    M_FREE = 2'd3
  } mode_e;

  // word index inside a 16-byte slot
  localparam logic [1:0] W_CTRL = 2'd0;
  localparam logic [1:0] W_SRC  = 2'd1;
  localparam logic [1:0] W_CNT  = 2'd2;
  localparam logic [1:0] W_CMP  = 2'd3;
  localparam logic [1:0] W_MASK = 2'd0;
  localparam logic [1:0] W_PEND = 2'd2;
endpackage

// File: rtl/gpt_channel.sv
module gpt_channel
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fast_tick_i,
  input  logic             slow_tick_i,
  input  logic             ctrl_we_i,
  input  logic             src_we_i,
  input  logic             cnt_we_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [31:0]      ctrl_o,
  output logic [31:0]      src_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             hit_o
);
  logic             en_q, slow_q, div2_q, phase_q;
  mode_e            mode_q;
  logic [CNT_W-1:0] cnt_q, cmp_q, nxt;
  logic             src_tick, cnt_tick, clr, reload;

  logic unused_bits;
  assign unused_bits = ^{wdata_i[CNT_W-1:6], wdata_i[3:2]};

  assign src_tick = slow_q ? slow_tick_i : fast_tick_i;
  assign cnt_tick = en_q && src_tick && (!div2_q || phase_q);
  assign clr      = ctrl_we_i && wdata_i[1];
  assign reload   = (mode_q == M_REP) && (cnt_q == cmp_q);
  assign nxt      = reload ? '0 : cnt_q + 1'b1;
  assign hit_o    = cnt_tick && !ctrl_we_i && !cnt_we_i &&
                    (mode_q != M_FREE) && (nxt == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      mode_q  <= M_ONCE;
      slow_q  <= 1'b0;
      div2_q  <= 1'b0;
      phase_q <= 1'b0;
      cnt_q   <= '0;
      cmp_q   <= '0;
    end else begin
      if (ctrl_we_i) begin
        en_q   <= wdata_i[0];
        mode_q <= mode_e'(wdata_i[5:4]);
      end else if (hit_o && mode_q != M_REP) begin
        en_q <= 1'b0;
      end
      if (src_we_i) begin
        slow_q <= wdata_i[4];
        div2_q <= wdata_i[0];
      end
      if (cmp_we_i) cmp_q <= wdata_i;
      if (clr)                                 phase_q <= 1'b0;
      else if (en_q && src_tick && div2_q)     phase_q <= ~phase_q;
      if (clr)           cnt_q <= '0;
      else if (cnt_we_i) cnt_q <= wdata_i;
      else if (cnt_tick) cnt_q <= nxt;
    end
  end

  assign ctrl_o = {26'b0, mode_q, 2'b0, 1'b0, en_q};
  assign src_o  = {27'b0, slow_q, 3'b0, div2_q};
  assign cnt_o  = cnt_q;
  assign cmp_o  = cmp_q;

  assert_clear_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> cnt_q == '0);
  assert_once_stops_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && mode_q != M_REP && !ctrl_we_i) |=> !en_q);
  assert_rep_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_tick && mode_q == M_REP && cnt_q == cmp_q && !ctrl_we_i && !cnt_we_i)
      |=> cnt_q == '0);
  assert_halt_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !ctrl_we_i && !cnt_we_i) |=> $stable(cnt_q));
endmodule

// File: rtl/gpt_irq.sv
module gpt_irq #(
  parameter int NUM_CH = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mask_we_i,
  input  logic              ack_we_i,
  input  logic [NUM_CH-1:0] wdata_i,
  input  logic [NUM_CH-1:0] hit_i,
  output logic [NUM_CH-1:0] mask_o,
  output logic [NUM_CH-1:0] pend_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] mask_q, pend_q, ack;

  assign ack = ack_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      if (mask_we_i) mask_q <= wdata_i;
      pend_q <= (pend_q & ~ack) | hit_i;  // set beats clear
    end
  end

  assign mask_o = mask_q;
  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & mask_q);

  assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i != '0) |=> (pend_q & $past(hit_i)) == $past(hit_i));
  assert_ack_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_we_i && (wdata_i & ~hit_i) != '0) |=> (pend_q & $past(wdata_i & ~hit_i)) == '0);
endmodule

// File: rtl/gp_timer_bank.sv
module gp_timer_bank
  import gpt_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fast_tick_i,
  input  logic              slow_tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  localparam int SLOT_W = ADDR_W - 4;

  logic [SLOT_W-1:0] slot;
  logic [1:0]        word;
  logic              wr;
  logic [NUM_CH-1:0] hit, mask, pend;
  logic [31:0]       ch_ctrl [NUM_CH];
  logic [31:0]       ch_src  [NUM_CH];
  logic [CNT_W-1:0]  ch_cnt  [NUM_CH];
  logic [CNT_W-1:0]  ch_cmp  [NUM_CH];
  logic [31:0]       rd_mux;

  assign slot = addr_i[ADDR_W-1:4];
  assign word = addr_i[3:2];
  assign wr   = req_i && we_i;

  logic unused_addr;
  assign unused_addr = ^addr_i[1:0];

  generate
    if (CNT_W < 32) begin : g_sink
      logic unused_wdata;
      assign unused_wdata = ^wdata_i[31:CNT_W];
    end
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic sel;
      assign sel = wr && (slot == SLOT_W'(i + 1));
      gpt_channel #(.CNT_W(CNT_W)) i_ch (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .fast_tick_i(fast_tick_i),
        .slow_tick_i(slow_tick_i),
        .ctrl_we_i  (sel && word == W_CTRL),
        .src_we_i   (sel && word == W_SRC),
        .cnt_we_i   (sel && word == W_CNT),
        .cmp_we_i   (sel && word == W_CMP),
        .wdata_i    (wdata_i[CNT_W-1:0]),
        .ctrl_o     (ch_ctrl[i]),
        .src_o      (ch_src[i]),
        .cnt_o      (ch_cnt[i]),
        .cmp_o      (ch_cmp[i]),
        .hit_o      (hit[i])
      );
    end
  endgenerate

  gpt_irq #(.NUM_CH(NUM_CH)) i_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mask_we_i(wr && slot == '0 && word == W_MASK),
    .ack_we_i (wr && slot == '0 && word == W_PEND),
    .wdata_i  (wdata_i[NUM_CH-1:0]),
    .hit_i    (hit),
    .mask_o   (mask),
    .pend_o   (pend),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    if (slot == '0) begin
      if (word == W_MASK)      rd_mux = 32'(mask);
      else if (word == W_PEND) rd_mux = 32'(pend);
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (slot == SLOT_W'(i + 1)) begin
        case (word)
          W_CTRL:  rd_mux = ch_ctrl[i];
          W_SRC:   rd_mux = ch_src[i];
          W_CNT:   rd_mux = 32'(ch_cnt[i]);
          default: rd_mux = 32'(ch_cmp[i]);
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_o <= '0;
    else if (req_i && !we_i) rdata_o <= rd_mux;
    else                     rdata_o <= '0;
  end

  assert_irq_low_in_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rst_ni) |-> !irq_o);
endmodule

// File: tb/test_gp_timer_bank.sv
module test_gp_timer_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fast = 1'b0, slow = 1'b0, req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  item_t cur;
  logic  chk_due = 1'b0;

  always #10 clk = ~clk;

  gp_timer_bank i_gp_timer_bank (
    .clk_i(clk), .rst_ni(rst_n), .fast_tick_i(fast), .slow_tick_i(slow),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  // monitor: compare read data the cycle after each read request
  always @(posedge clk) chk_due <= req && !we;
  always @(negedge clk) begin
    if (chk_due && q.size() > 0) begin
      cur = q.pop_front();
      n_vec++;
      if (rdata !== cur.exp) begin
        n_bad++;
        $display("FAIL %s: rdata=%h expected %h", cur.tag, rdata, cur.exp);
      end
    end
  end

  task automatic drive(input logic w, input logic [7:0] a, input logic [31:0] d,
                       input logic f, input logic s, input logic r);
    req = r; we = w; addr = a; wdata = d; fast = f; slow = s;
    @(negedge clk);
    req = 0; we = 0; fast = 0; slow = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    drive(1'b1, a, d, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    q.push_back(it);
    drive(1'b0, a, '0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic tick(input logic f, input logic s, input int n);
    for (int i = 0; i < n; i++) drive(1'b0, '0, '0, f, s, 1'b0);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    n_vec++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s: irq=%b expected %b", tag, irq, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_irq(1'b0, "R1 irq");
    rd(8'h00, 0, "R1 mask"); rd(8'h08, 0, "R1 pend");
    rd(8'h10, 0, "R1 ctrl"); rd(8'h14, 0, "R1 src");
    rd(8'h18, 0, "R1 cnt");  rd(8'h1C, 0, "R1 cmp");
    rd(8'h6C, 0, "R1 ch6 cmp");
    // channel 1, restart mode on fast tick
    wr(8'h1C, 3); wr(8'h14, 0); wr(8'h10, 32'h13); wr(8'h00, 1);
    rd(8'h10, 32'h11, "R2 clear reads 0");
    rd(8'h18, 0, "R3 cleared");
    tick(1, 0, 2);
    rd(8'h18, 2, "R4 fast count");
    chk_irq(1'b0, "R9 no flag");
    tick(1, 0, 1);
    rd(8'h18, 3, "R6 reach compare");
    rd(8'h08, 1, "R6 flag");
    chk_irq(1'b1, "R9 masked on");
    tick(1, 0, 1);
    rd(8'h18, 0, "R6 reload");
    rd(8'h08, 1, "R6 flag held");
    wr(8'h08, 1);
    rd(8'h08, 0, "R10 ack");
    chk_irq(1'b0, "R9 after ack");
    tick(1, 0, 3);
    rd(8'h08, 1, "R6 period");
    rd(8'h18, 3, "R6 period cnt");
    // R8 stop keeps settings
    wr(8'h10, 32'h10);
    rd(8'h10, 32'h10, "R8 mode kept");
    tick(1, 0, 2);
    rd(8'h18, 3, "R8 frozen");
    rd(8'h1C, 3, "R8 cmp kept");
    rd(8'h14, 0, "R8 src kept");
    // R3 clear with enable
    wr(8'h10, 32'h13);
    rd(8'h18, 0, "R3 zeroed");
    tick(1, 0, 1);
    rd(8'h18, 1, "R3 from zero");
    wr(8'h10, 32'h10);
    wr(8'h08, 32'h3F);
    // channel 2, stop-at-match, slow tick halved
    wr(8'h24, 32'h11); wr(8'h2C, 2); wr(8'h20, 32'h03);
    tick(1, 0, 3);
    rd(8'h28, 0, "R4 other source ignored");
    tick(0, 1, 1);
    rd(8'h28, 0, "R4 div2 first");
    tick(0, 1, 1);
    rd(8'h28, 1, "R4 div2 second");
    tick(0, 1, 2);
    rd(8'h28, 2, "R5 reach");
    rd(8'h08, 2, "R5 flag");
    rd(8'h20, 0, "R5 run dropped");
    chk_irq(1'b0, "R9 unmasked flag");
    tick(0, 1, 4);
    rd(8'h28, 2, "R5 hold");
    wr(8'h00, 3);
    chk_irq(1'b1, "R9 mask set");
    rd(8'h24, 32'h11, "R2 src readback");
    // channel 3, free run wrap
    wr(8'h3C, 0); wr(8'h38, 32'hFFFF_FFFE); wr(8'h30, 32'h31);
    rd(8'h38, 32'hFFFF_FFFE, "R2 cnt write");
    tick(1, 0, 1);
    rd(8'h38, 32'hFFFF_FFFF, "R7 top");
    tick(1, 0, 1);
    rd(8'h38, 0, "R7 wrap");
    tick(1, 0, 1);
    rd(8'h38, 1, "R7 continue");
    rd(8'h08, 2, "R7 no flag");
    // channel 4: match and acknowledge on one edge
    wr(8'h4C, 1); wr(8'h40, 32'h13);
    drive(1'b1, 8'h08, 32'h0A, 1'b1, 1'b0, 1'b1);
    rd(8'h08, 32'h08, "R10 set wins, other cleared");
    chk_irq(1'b0, "R9 ch4 unmasked");
    wr(8'h00, 32'h3F);
    chk_irq(1'b1, "R9 ch4 masked");
    wr(8'h08, 32'h3F);
    chk_irq(1'b0, "R10 all cleared");
    // R11 independence and unused space
    wr(8'h6C, 32'h1234);
    rd(8'h6C, 32'h1234, "R11 ch6 cmp");
    rd(8'h4C, 1, "R11 ch4 cmp");
    rd(8'h38, 2, "R11 ch3 cnt");
    rd(8'h18, 1, "R11 ch1 cnt");
    rd(8'h70, 0, "R2 empty slot");
    rd(8'h04, 0, "R2 reserved word");
    @(negedge clk);
    finish_run();
  end
endmodule